// File: doc/BRIEF.md
# Tree Arbiter Issue Select

This block picks which ready entries of an issue window go to execution units in a given cycle. Each window slot presents one request bit. The requests feed a tree of four-input arbiter cells. Each cell reports upward whether any of its inputs is requesting. The enable coming down from the root is steered to the lowest-indexed requesting input, so lower window entries always win.

Two identical execution units are served by two select trees connected in series. The first tree is enabled only when unit 0 is free. The second tree sees the same requests, with the entry that the first tree picked removed, and is enabled only when unit 1 is free. Both trees are purely combinational. Their one-hot grant vectors are registered once, so each grant appears at the outputs on the clock edge that follows the request.

Top module: `issue_sel_top`

## Requirements
- R1: While rst_ni is low, and on the first edge after its release, both grant outputs are all zero.
- R2: One clock after a cycle with requests and unit0_free_i high, gnt0_o holds exactly the lowest set bit of req_i. Bit i is window entry i, and entry 0 has the highest priority.
- R3: One clock after a cycle where unit1_free_i is high, gnt1_o holds the lowest set bit of req_i with the bit granted to unit 0 removed. If no such bit remains, gnt1_o is zero.
- R4: A unit whose free input was low receives an all-zero grant. When unit 0 is busy, unit 1 receives the lowest requesting entry overall.
- R5: When req_i is all zero, both grants on the next cycle are all zero, whatever the free inputs are.
- R6: Each grant vector is one-hot or zero. The two grant vectors never share a bit. Every granted bit was set in req_i one cycle earlier.
- R7: With a single request and both units free, only unit 0 receives it, and gnt1_o is zero.
- R8: Priority holds across the arbiter cells of different subtrees. For example, entries 5 and 15 requesting give entry 5 to unit 0 and entry 15 to unit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | WIN | Ready bit of each window entry; bit 0 has the highest priority |
| unit0_free_i | input | 1 | Unit 0 can accept an operation this cycle |
| unit1_free_i | input | 1 | Unit 1 can accept an operation this cycle |
| gnt0_o | output | WIN | Registered one-hot grant to unit 0 |
| gnt1_o | output | WIN | Registered one-hot grant to unit 1 |

## Verification
A bad enable path or a bad priority decision inside a cell shows up at the ports exactly one clock later. It appears as a grant on a higher-indexed entry than expected, as two set bits, or as a grant to a busy unit. A broken mask between the two stages shows up in the same cycle as the unit 1 grant colliding with the unit 0 grant. Request patterns that straddle the leaf cells expose faults in the upper tree levels, which single-cell patterns never reach.

// File: rtl/sel_pkg.sv
package sel_pkg;
  // number of base-4 levels needed to cover n leaves
  function automatic int clog4(input int n);
    int lv = 0;
    int span = 1;
    while (span < n) begin
      span = span * 4;
      lv++;
    end
    return lv;
  endfunction
endpackage

// File: rtl/sel_arb4_cell.sv
module sel_arb4_cell (
  input  logic [3:0] req_i,
  input  logic       en_i,
  output logic       any_o,
  output logic [3:0] gnt_o
);
  assign any_o = |req_i;

  always_comb begin
    gnt_o = '0;
    if (en_i) begin
      if (req_i[0])      gnt_o[0] = 1'b1;
      else if (req_i[1]) gnt_o[1] = 1'b1;
      else if (req_i[2]) gnt_o[2] = 1'b1;
      else if (req_i[3]) gnt_o[3] = 1'b1;
    end
  end
endmodule

// File: rtl/sel_tree.sv
module sel_tree #(
  parameter int WIN = 16
) (
  input  logic [WIN-1:0] req_i,
  input  logic           en_i,
  output logic           any_o,
  output logic [WIN-1:0] gnt_o
);
  localparam int LEVELS = sel_pkg::clog4(WIN);

  // level 0 holds the leaf cells; level LEVELS-1 is the root
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int NCELL = WIN >> (2 * (l + 1));
    logic [4*NCELL-1:0] req_in;
    logic [4*NCELL-1:0] en_out;
    logic [NCELL-1:0]   any_out;
    logic [NCELL-1:0]   en_in;

    if (l == 0) begin : g_leaf
      assign req_in = req_i;
    end else begin : g_inner
      assign req_in = g_lvl[l-1].any_out;
    end

    if (l == LEVELS - 1) begin : g_root
      assign en_in = en_i;
    end else begin : g_mid
      assign en_in = g_lvl[l+1].en_out;
    end

    for (genvar j = 0; j < NCELL; j++) begin : g_cell
      sel_arb4_cell u_cell (
        .req_i (req_in[4*j +: 4]),
        .en_i  (en_in[j]),
        .any_o (any_out[j]),
        .gnt_o (en_out[4*j +: 4])
      );
    end
  end

  assign gnt_o = g_lvl[0].en_out;
  assign any_o = g_lvl[LEVELS-1].any_out[0];
endmodule

// File: rtl/issue_sel_top.sv
module issue_sel_top #(
  parameter int WIN = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [WIN-1:0] req_i,
  input  logic           unit0_free_i,
  input  logic           unit1_free_i,
  output logic [WIN-1:0] gnt0_o,
  output logic [WIN-1:0] gnt1_o
);
  logic [WIN-1:0] gnt0_c, gnt1_c, req_s1;
  logic           any0, any1;

  sel_tree #(.WIN(WIN)) u_tree0 (
    .req_i (req_i),
    .en_i  (unit0_free_i),
    .any_o (any0),
    .gnt_o (gnt0_c)
  );

  // second unit: drop the entry already taken by the first
  assign req_s1 = req_i & ~gnt0_c;

  sel_tree #(.WIN(WIN)) u_tree1 (
    .req_i (req_s1),
    .en_i  (unit1_free_i),
    .any_o (any1),
    .gnt_o (gnt1_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt0_o <= '0;
      gnt1_o <= '0;
    end else begin
      gnt0_o <= gnt0_c;
      gnt1_o <= gnt1_c;
    end
  end
endmodule

// File: rtl/issue_sel_chk.sv
module issue_sel_chk #(
  parameter int WIN = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [WIN-1:0] req_i,
  input logic           unit0_free_i,
  input logic           unit1_free_i,
  input logic           any0,
  input logic           any1,
  input logic [WIN-1:0] gnt0_o,
  input logic [WIN-1:0] gnt1_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt0_o) && $onehot0(gnt1_o));

  p_disjoint_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt0_o & gnt1_o) == '0);

  p_was_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((gnt0_o | gnt1_o) & ~$past(req_i)) == '0);

  p_busy0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(unit0_free_i) |-> gnt0_o == '0);

  p_busy1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(unit1_free_i) |-> gnt1_o == '0);

  p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(req_i) == '0 |-> (gnt0_o == '0) && (gnt1_o == '0));

  p_served_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(any0 && unit0_free_i) |-> gnt0_o != '0);

  p_lowest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && gnt0_o != '0 |-> ((gnt0_o - 1'b1) & $past(req_i)) == '0);

  p_second_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(any1 && unit1_free_i) |-> gnt1_o != '0);
endmodule

bind issue_sel_top issue_sel_chk #(.WIN(WIN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .unit0_free_i (unit0_free_i),
  .unit1_free_i (unit1_free_i),
  .any0         (any0),
  .any1         (any1),
  .gnt0_o       (gnt0_o),
  .gnt1_o       (gnt1_o)
);

// File: tb/issue_sel_top_test.sv
module issue_sel_top_test;
  localparam int WIN = 16;

  typedef struct {
    logic [WIN-1:0] g0;
    logic [WIN-1:0] g1;
    string          tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [WIN-1:0] req = '0;
  logic           f0 = 1'b0;
  logic           f1 = 1'b0;
  logic [WIN-1:0] gnt0, gnt1;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;

  issue_sel_top #(.WIN(WIN)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_i        (req),
    .unit0_free_i (f0),
    .unit1_free_i (f1),
    .gnt0_o       (gnt0),
    .gnt1_o       (gnt1)
  );

  function automatic logic [WIN-1:0] lowest(input logic [WIN-1:0] v);
    for (int i = 0; i < WIN; i++) if (v[i]) return WIN'(1) << i;
    return '0;
  endfunction

  task automatic check(input string tag, input logic [WIN-1:0] a0, input logic [WIN-1:0] a1,
                       input logic [WIN-1:0] e0, input logic [WIN-1:0] e1);
    n_vec++;
    if (a0 !== e0 || a1 !== e1) begin
      n_bad++;
      $display("FAIL %s: gnt0=%h gnt1=%h expected gnt0=%h gnt1=%h", tag, a0, a1, e0, e1);
    end
  endtask

  task automatic apply(input logic [WIN-1:0] r, input logic u0, input logic u1, input string tag);
    exp_t e;
    @(negedge clk);
    req = r; f0 = u0; f1 = u1;
    e.g0  = u0 ? lowest(r) : '0;
    e.g1  = u1 ? lowest(r & ~e.g0) : '0;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: one expected item per edge after it was driven
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, gnt0, gnt1, e.g0, e.g1);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    logic [WIN-1:0] lfsr;
    req = 16'hFFFF; f0 = 1'b1; f1 = 1'b1;
    #20;
    check("R1 in reset", gnt0, gnt1, '0, '0);
    @(negedge clk);
    req = '0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 first edge", gnt0, gnt1, '0, '0);

    apply(16'h0008, 1'b1, 1'b1, "R7 single request");
    apply(16'h00A0, 1'b1, 1'b1, "R2 R3 two in one cell");
    apply(16'h8020, 1'b1, 1'b1, "R8 across subtrees");
    apply(16'h8000, 1'b1, 1'b1, "R8 top entry only");
    apply(16'hFFFF, 1'b1, 1'b1, "R2 R3 all requesting");
    apply(16'h0110, 1'b0, 1'b1, "R4 unit0 busy");
    apply(16'h0110, 1'b1, 1'b0, "R4 unit1 busy");
    apply(16'h0110, 1'b0, 1'b0, "R4 both busy");
    apply(16'h0000, 1'b1, 1'b1, "R5 no requests");
    apply(16'h0000, 1'b0, 1'b1, "R5 no requests busy");
    apply(16'h0001, 1'b1, 1'b1, "R7 entry zero");
    apply(16'h1001, 1'b1, 1'b1, "R8 far apart");
    apply(16'hF000, 1'b0, 1'b1, "R4 R8 upper cell unit1 only");

    lfsr = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr & {lfsr[7:0], lfsr[15:8]}, lfsr[3] | lfsr[9], lfsr[5] | lfsr[1], "R6 sweep");
    end

    @(negedge clk);
    req = '0;
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule